// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Sequencer

This block sits between an internal bus master and the external memory pins. It decodes a 24-bit byte address against four programmable address windows and drives one chip-select line for the window that was hit, or a fifth line for everything else. It then times the external bus cycle. A cycle always lasts at least two states. Each window adds its own number of wait states, with separate counts for reads and for writes. An external hold input can stretch the final state, and after a read a one-state recovery gap can keep the selected device off the bus long enough to meet data hold time.

Each window has an enable bit, an 8-bit base value that is compared against address bits 23 to 16, and a 16-bit ignore mask over address bits 23 to 8. Together these set window sizes from 256 bytes upward. The timing fields (read waits, write waits, recovery, hold enable) come as one set per window plus one set for the default line. A request is taken only while the sequencer is idle.

Top module: `csw_gen`

## Requirements
- R1: An enabled window k hits when, for every address bit 23..8 whose ignore-mask bit is 0 (mask bit i covers address bit i+8), the address bit equals the matching bit of {base, 8'h00}. When window k is selected, cs[k] is driven high and all other cs bits are low.
- R2: When several enabled windows hit, the window with the lowest index is selected.
- R3: An address that hits no enabled window selects the default line cs[4]. A window whose enable bit is 0 never hits.
- R4: A request sampled at a clock edge while idle raises the chip-select and the strobe on the next clock. Both stay high for 2+N clocks, where N is the wait count, and the selection stays unchanged during that time.
- R5: A read (req_write=0) takes N from the selected line's read-wait field and raises rd_stb. A write takes N from the write-wait field and raises wr_stb. The two strobes are never high together.
- R6: While the selected line's hold-enable bit is 1, wait_hold high during the final state keeps that state (cs, strobe, busy) for another clock and suppresses done. While the bit is 0, wait_hold has no effect.
- R7: After a read on a line whose recovery bit is 1, there is one extra clock with all cs and strobes low and busy high. After a write, or when the bit is 0, there is no such clock.
- R8: done is high for exactly one clock, in the final state of the cycle. Requests presented while busy is high are ignored.
- R9: During reset, cs, rd_stb, wr_stb, done and busy are all low.
- R10: At most one chip-select line is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address of the access |
| wait_hold | input | 1 | External request to stretch the final state |
| cfg_enable | input | 4 | Enable per window |
| cfg_base | input | 32 | 8-bit base per window (window k at bits 8k+7..8k) |
| cfg_mask | input | 64 | 16-bit ignore mask per window over address bits 23..8 |
| cfg_rd_wait | input | 20 | 4-bit read-wait count per line, line 4 = default |
| cfg_wr_wait | input | 20 | 4-bit write-wait count per line, line 4 = default |
| cfg_recover | input | 5 | Read recovery gap enable per line |
| cfg_xwait_en | input | 5 | Honour wait_hold per line |
| cs | output | 5 | Chip-select lines, active high, bit 4 = default |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | Final state of the cycle completes this clock |
| busy | output | 1 | Sequencer not idle |

## Verification
The hardest conditions to create are overlapping windows, where priority rather than the base value decides the selection, and a hold that arrives exactly in the final state on a line with and without hold enabled. The stimulus programs two windows whose ranges intersect, disables the winner to expose the loser, and drives wait_hold only in the cycles the reference model computes as the final state. It also keeps a different request on the inputs for the whole of one busy cycle, to show that the selection and the length do not move.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FIRST = 3'd1,
      ST_WAIT  = 3'd2,
      ST_LAST  = 3'd3,
      ST_GAP   = 3'd4
   } csw_state_e;

endpackage

// File: rtl/csw_decode.sv
`timescale 1ns/1ps
module csw_decode #(
   parameter int NUM_SPACES = 4,
   parameter int MASK_W     = 16,
   parameter int BASE_W     = 8,
   parameter int SEL_W      = 3
) (
   input  logic [MASK_W-1:0]            addr_hi,
   input  logic [NUM_SPACES-1:0]        enable,
   input  logic [NUM_SPACES*BASE_W-1:0] base,
   input  logic [NUM_SPACES*MASK_W-1:0] mask,
   output logic [SEL_W-1:0]             sel
);

   localparam int PAD_W = MASK_W - BASE_W;

   logic [NUM_SPACES-1:0] hit;

   for (genvar k = 0; k < NUM_SPACES; k++) begin : g_win
      logic [MASK_W-1:0] ref_hi;
      logic [MASK_W-1:0] diff;
      if (PAD_W > 0) begin : g_pad
         assign ref_hi = {base[k*BASE_W +: BASE_W], {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign ref_hi = base[k*BASE_W +: BASE_W];
      end
      assign diff   = (addr_hi ^ ref_hi) & ~mask[k*MASK_W +: MASK_W];
      assign hit[k] = enable[k] && (diff == '0);
   end

   // lowest index wins; no hit leaves the default line
   always_comb begin
      sel = SEL_W'(NUM_SPACES);
      for (int k = NUM_SPACES - 1; k >= 0; k--) begin
         if (hit[k]) sel = SEL_W'(k);
      end
   end

endmodule

// File: rtl/csw_seq.sv
`timescale 1ns/1ps
module csw_seq
   import csw_pkg::*;
#(
   parameter int NUM_LINES = 5,
   parameter int WAIT_W    = 4,
   parameter int SEL_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [SEL_W-1:0]     sel_in,
   input  logic                 is_write,
   input  logic [WAIT_W-1:0]    waits,
   input  logic                 recover,
   input  logic                 xwait_en,
   input  logic                 wait_hold,
   output logic [NUM_LINES-1:0] cs,
   output logic                 rd_stb,
   output logic                 wr_stb,
   output logic                 done,
   output logic                 busy
);

   csw_state_e        state;
   logic [WAIT_W-1:0] cnt;
   logic [SEL_W-1:0]  sel_q;
   logic              wr_q;
   logic              rec_q;
   logic              xw_q;
   logic              stall;
   logic              active;

   assign stall  = xw_q && wait_hold;
   assign active = (state == ST_FIRST) || (state == ST_WAIT) || (state == ST_LAST);
   assign done   = (state == ST_LAST) && !stall;
   assign busy   = (state != ST_IDLE);
   assign rd_stb = active && !wr_q;
   assign wr_stb = active && wr_q;

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_cs
      assign cs[k] = active && (sel_q == SEL_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         sel_q <= '0;
         wr_q  <= 1'b0;
         rec_q <= 1'b0;
         xw_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  sel_q <= sel_in;
                  wr_q  <= is_write;
                  cnt   <= waits;
                  rec_q <= recover && !is_write;
                  xw_q  <= xwait_en;
                  state <= ST_FIRST;
               end
            end
            ST_FIRST: state <= (cnt == '0) ? ST_LAST : ST_WAIT;
            ST_WAIT: begin
               cnt <= cnt - 1'b1;
               if (cnt == WAIT_W'(1)) state <= ST_LAST;
            end
            ST_LAST: begin
               if (!stall) state <= rec_q ? ST_GAP : ST_IDLE;
            end
            ST_GAP:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   assert_min_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|cs) |=> (|cs));

   assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cs) && !done) |=> $stable(cs));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cs) && xw_q && wait_hold && (state == ST_LAST)) |=> ((|cs) && $stable(cs)));

   assert_gap_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_stb && rec_q) |=> (busy && (cs == '0)));

endmodule

// File: rtl/csw_gen.sv
`timescale 1ns/1ps
module csw_gen #(
   parameter int NUM_SPACES = 4,
   parameter int ADDR_W     = 24,
   parameter int BASE_W     = 8,
   parameter int BLK_BITS   = 8,
   parameter int WAIT_W     = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic                                      req_write,
   input  logic [ADDR_W-1:0]                         req_addr,
   input  logic                                      wait_hold,
   input  logic [NUM_SPACES-1:0]                     cfg_enable,
   input  logic [NUM_SPACES*BASE_W-1:0]              cfg_base,
   input  logic [NUM_SPACES*(ADDR_W-BLK_BITS)-1:0]   cfg_mask,
   input  logic [(NUM_SPACES+1)*WAIT_W-1:0]          cfg_rd_wait,
   input  logic [(NUM_SPACES+1)*WAIT_W-1:0]          cfg_wr_wait,
   input  logic [NUM_SPACES:0]                       cfg_recover,
   input  logic [NUM_SPACES:0]                       cfg_xwait_en,
   output logic [NUM_SPACES:0]                       cs,
   output logic                                      rd_stb,
   output logic                                      wr_stb,
   output logic                                      done,
   output logic                                      busy
);

   localparam int MASK_W    = ADDR_W - BLK_BITS;
   localparam int NUM_LINES = NUM_SPACES + 1;
   localparam int SEL_W     = $clog2(NUM_LINES);

   if (NUM_SPACES < 1) begin : g_bad_count
      $error("csw_gen: NUM_SPACES must be at least 1");
   end
   if (ADDR_W < BASE_W + BLK_BITS) begin : g_bad_addr
      $error("csw_gen: ADDR_W too small for BASE_W + BLK_BITS");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("csw_gen: WAIT_W must be at least 1");
   end

   logic [SEL_W-1:0]  sel;
   logic [WAIT_W-1:0] rd_w;
   logic [WAIT_W-1:0] wr_w;
   logic              unused_addr_lo;

   assign unused_addr_lo = ^req_addr[BLK_BITS-1:0];

   csw_decode #(
      .NUM_SPACES (NUM_SPACES),
      .MASK_W     (MASK_W),
      .BASE_W     (BASE_W),
      .SEL_W      (SEL_W)
   ) u_decode (
      .addr_hi (req_addr[ADDR_W-1:BLK_BITS]),
      .enable  (cfg_enable),
      .base    (cfg_base),
      .mask    (cfg_mask),
      .sel     (sel)
   );

   assign rd_w = cfg_rd_wait[sel*WAIT_W +: WAIT_W];
   assign wr_w = cfg_wr_wait[sel*WAIT_W +: WAIT_W];

   csw_seq #(
      .NUM_LINES (NUM_LINES),
      .WAIT_W    (WAIT_W),
      .SEL_W     (SEL_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_valid),
      .sel_in    (sel),
      .is_write  (req_write),
      .waits     (req_write ? wr_w : rd_w),
      .recover   (cfg_recover[sel]),
      .xwait_en  (cfg_xwait_en[sel]),
      .wait_hold (wait_hold),
      .cs        (cs),
      .rd_stb    (rd_stb),
      .wr_stb    (wr_stb),
      .done      (done),
      .busy      (busy)
   );

endmodule

// File: tb/csw_gen_bench.sv
`timescale 1ns/1ps
module csw_gen_bench;

   localparam int NS = 4;
   localparam int NL = NS + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic        wait_hold = 1'b0;
   logic [NS-1:0] en_v;
   logic [7:0]  base_v [NS];
   logic [15:0] mask_v [NS];
   logic [3:0]  rdw_v  [NL];
   logic [3:0]  wrw_v  [NL];
   logic [NL-1:0] rec_v;
   logic [NL-1:0] xw_v;

   logic [NS*8-1:0]  cfg_base;
   logic [NS*16-1:0] cfg_mask;
   logic [NL*4-1:0]  cfg_rd_wait;
   logic [NL*4-1:0]  cfg_wr_wait;
   logic [NL-1:0]    cs;
   logic rd_stb, wr_stb, done, busy;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NS; k++) begin
         cfg_base[k*8 +: 8]   = base_v[k];
         cfg_mask[k*16 +: 16] = mask_v[k];
      end
      for (int k = 0; k < NL; k++) begin
         cfg_rd_wait[k*4 +: 4] = rdw_v[k];
         cfg_wr_wait[k*4 +: 4] = wrw_v[k];
      end
   end

   csw_gen u_csw_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .wait_hold    (wait_hold),
      .cfg_enable   (en_v),
      .cfg_base     (cfg_base),
      .cfg_mask     (cfg_mask),
      .cfg_rd_wait  (cfg_rd_wait),
      .cfg_wr_wait  (cfg_wr_wait),
      .cfg_recover  (rec_v),
      .cfg_xwait_en (xw_v),
      .cs           (cs),
      .rd_stb       (rd_stb),
      .wr_stb       (wr_stb),
      .done         (done),
      .busy         (busy)
   );

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic cmp(input logic [NL-1:0] e_cs, input logic e_rd, input logic e_wr,
                      input logic e_done, input logic e_busy, input string tag);
      n_checks++;
      if ({cs, rd_stb, wr_stb, done, busy} !== {e_cs, e_rd, e_wr, e_done, e_busy}) begin
         n_fail++;
         $display("FAIL %s: got cs=%b rd=%b wr=%b done=%b busy=%b, expected cs=%b rd=%b wr=%b done=%b busy=%b",
                  tag, cs, rd_stb, wr_stb, done, busy, e_cs, e_rd, e_wr, e_done, e_busy);
      end
   endtask

   // reference decode: lowest enabled window whose unmasked bits match
   function automatic int ref_sel(input logic [23:0] a);
      for (int k = 0; k < NS; k++) begin
         bit ok = en_v[k];
         for (int b = 0; b < 16; b++) begin
            logic want = (b >= 8) ? base_v[k][b-8] : 1'b0;
            if (!mask_v[k][b] && (a[b+8] !== want)) ok = 0;
         end
         if (ok) return k;
      end
      return NS;
   endfunction

   // called at a negedge with the design idle; returns at a negedge, idle
   task automatic xact(input logic [23:0] a, input logic w, input int hold,
                       input bit junk, input string tag);
      int s    = ref_sel(a);
      int n    = w ? int'(wrw_v[s]) : int'(rdw_v[s]);
      int len  = n + 2;
      int heff = xw_v[s] ? hold : 0;
      logic [NL-1:0] ecs = NL'(1) << s;
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      @(negedge clk);
      if (junk) begin
         req_write = ~w;
         req_addr  = 24'h800000;
      end else begin
         req_valid = 1'b0;
      end
      for (int i = 0; i < len + heff; i++) begin
         bit last = (i >= len - 1);
         wait_hold = last && ((i - (len - 1)) < hold);
         #1;
         cmp(ecs, !w, w, last && !(wait_hold && xw_v[s]), 1'b1, tag);
         @(negedge clk);
      end
      wait_hold = 1'b0;
      req_valid = 1'b0;
      if (!w && rec_v[s]) begin
         #1;
         cmp('0, 1'b0, 1'b0, 1'b0, 1'b1, {tag, " gap"});
         @(negedge clk);
      end
      #1;
      cmp('0, 1'b0, 1'b0, 1'b0, 1'b0, {tag, " idle"});
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no end, expected end of run");
      report();
   end

   initial begin
      en_v = 4'b1111;
      base_v[0] = 8'h01; mask_v[0] = 16'h00FF;
      base_v[1] = 8'h20; mask_v[1] = 16'h0FFF;
      base_v[2] = 8'h21; mask_v[2] = 16'h00FF;
      base_v[3] = 8'h80; mask_v[3] = 16'h0000;
      rdw_v[0] = 4'd0; wrw_v[0] = 4'd0;
      rdw_v[1] = 4'd3; wrw_v[1] = 4'd1;
      rdw_v[2] = 4'd1; wrw_v[2] = 4'd15;
      rdw_v[3] = 4'd2; wrw_v[3] = 4'd0;
      rdw_v[4] = 4'd0; wrw_v[4] = 4'd2;
      rec_v = 5'b01010;
      xw_v  = 5'b11000;

      // R9: outputs low in reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         cmp('0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 reset");
      end
      rst_n = 1'b1;
      @(negedge clk);

      xact(24'h012345, 1'b0, 0, 0, "R1 R4 read window0");
      xact(24'h01FFFF, 1'b1, 0, 0, "R1 R4 write window0 top");
      xact(24'h020000, 1'b0, 0, 0, "R3 R1 just past window0");
      xact(24'h2ABCDE, 1'b0, 0, 0, "R5 R7 read window1 gap");
      xact(24'h2ABCDE, 1'b1, 0, 0, "R5 R7 write window1 no gap");
      xact(24'h210042, 1'b0, 0, 0, "R2 overlap lowest wins");
      xact(24'h800010, 1'b0, 3, 0, "R6 hold extends window3");
      xact(24'h8000FF, 1'b1, 1, 0, "R6 R10 write window3");
      xact(24'h800100, 1'b0, 2, 0, "R3 R6 default hold");
      xw_v[4] = 1'b0;
      xact(24'h800100, 1'b1, 3, 0, "R6 hold ignored default");
      xact(24'h2FFFFF, 1'b0, 0, 1, "R8 requests ignored busy");
      en_v[1] = 1'b0;
      xact(24'h210042, 1'b0, 0, 0, "R3 R2 window1 disabled");
      xact(24'h21FF00, 1'b1, 0, 0, "R5 max write waits");
      en_v = 4'b0000;
      xact(24'h012345, 1'b0, 0, 0, "R3 all disabled");
      en_v = 4'b0001;
      mask_v[0] = 16'hFFFF;
      xact(24'hFEDCBA, 1'b1, 0, 0, "R1 full mask");
      report();
   end

endmodule